// File: doc/BRIEF.md
# Multichannel SPI Interrupt Aggregator

This block gathers transmit-empty and receive-full events from up to four SPI channels into one sticky 17-bit status word. Each channel owns a 4-bit slice of that word. A software-written enable word masks the status, and a registered, level-sensitive interrupt line is raised while any enabled status bit is set. Software acknowledges events by writing ones to the status word. Serial shifting, DMA requests and address decoding stay outside the block. Register accesses reach it as one write strobe per register and a shared data bus.

A small test-mode state machine watches two bits: the system-test bit (bit 3) of the 4-bit module-control register and the force bit (bit 11) of the 12-bit test register. It has four states:
- `TM_OFF`: neither bit is set.
- `TM_SSB_ONLY`: only the force bit is set.
- `TM_ARMED`: only the system-test bit is set.
- `TM_LOCKED`: both bits are set.

After every write to the test or control register, the next state is chosen from the bit pair the write leaves behind. Any of the four states can move to any other. A write that lands in `TM_LOCKED`, including a rewrite while already there, sets every implemented status bit. While in `TM_LOCKED`, software clears of the status word are ignored.

Top module: `mspi_irq_agg`

## Requirements
- R1: After reset, status, enable and test read 0, control reads 4, and the interrupt line is low.
- R2: A pulse on `ev_txe[n]` sets status bit 4*n; a pulse on `ev_rxf[n]` sets status bit 4*n+2. Set bits stay set until cleared.
- R3: Writing the status register clears each bit written as 1 and leaves bits written as 0 unchanged.
- R4: The enable register stores only the bits of mask 0x1777F; every other bit reads as zero.
- R5: The interrupt line is high one clock after the AND of status and enable becomes nonzero, and low one clock after it becomes zero.
- R6: When an event pulse and a software clear hit the same bit in the same cycle, the bit ends up set.
- R7: While control bit 3 and test bit 11 are both set, writes to the status register change nothing.
- R8: A test-register write with bit 11 set, made while control bit 3 is set, makes status equal to 0x1777F (plus nothing outside it).
- R9: A control write with bit 3 set, made while test bit 11 is set, makes status equal to 0x1777F.
- R10: The test register keeps data bits 11:0, and the control register keeps data bits 3:0.
- R11: A test or control write that leaves at least one of control bit 3 and test bit 11 clear does not change the status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_txe | input | NUM_CH | Per-channel transmit-empty set pulse |
| ev_rxf | input | NUM_CH | Per-channel receive-full set pulse |
| wr_status | input | 1 | Write strobe, status register (write 1 to clear) |
| wr_enable | input | 1 | Write strobe, enable register |
| wr_test | input | 1 | Write strobe, test register |
| wr_ctrl | input | 1 | Write strobe, module-control register |
| wr_data | input | 17 | Write data shared by all strobes |
| status_q | output | 17 | Status readback |
| enable_q | output | 17 | Enable readback |
| test_q | output | 12 | Test register readback |
| ctrl_q | output | 4 | Module-control readback |
| irq | output | 1 | Registered interrupt line |

## Verification
The embedded assertions check these rules on every cycle:
- event pulses always leave their bits set;
- status loses no bit while the state machine is in `TM_LOCKED`;
- a forcing write always fills the implemented mask;
- an unlocked clear removes exactly the written bits;
- the state machine agrees with the two register bits;
- the interrupt follows the masked status one cycle later.

Only the bench scenarios can show the rest: the exact bit positions per channel, the set-over-clear tie, the enable mask, that a non-forcing test or control write leaves status alone, and both ways of entering the locked state. The bench covers these through directed cases and a long seeded random run against a bench-side model.

// File: rtl/mspi_irq_pkg.sv
package mspi_irq_pkg;
    localparam int STAT_W      = 17;
    localparam int TEST_W      = 12;
    localparam int CTRL_W      = 4;
    localparam int SLICE_W     = 4;
    localparam int TXE_OFS     = 0;
    localparam int RXF_OFS     = 2;
    localparam int SYSTEST_BIT = 3;
    localparam int FORCE_BIT   = 11;
    localparam logic [STAT_W-1:0] IMPL_MASK = 17'h1777F;
    localparam logic [CTRL_W-1:0] CTRL_RST  = 4'h4;

    typedef enum logic [1:0] {
        TM_OFF      = 2'd0,
        TM_SSB_ONLY = 2'd1,
        TM_ARMED    = 2'd2,
        TM_LOCKED   = 2'd3
    } tmode_e;
endpackage

// File: rtl/mspi_irq_mode.sv
module mspi_irq_mode
    import mspi_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_test,
    input  logic              wr_ctrl,
    input  logic [TEST_W-1:0] wr_data,
    output logic [TEST_W-1:0] test_q,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              force_all,
    output logic              locked
);
    tmode_e            state_q, state_d;
    logic [TEST_W-1:0] test_d;
    logic [CTRL_W-1:0] ctrl_d;

    always_comb begin
        test_d = wr_test ? wr_data : test_q;
        ctrl_d = wr_ctrl ? wr_data[CTRL_W-1:0] : ctrl_q;
        unique case ({ctrl_d[SYSTEST_BIT], test_d[FORCE_BIT]})
            2'b00:   state_d = TM_OFF;
            2'b01:   state_d = TM_SSB_ONLY;
            2'b10:   state_d = TM_ARMED;
            default: state_d = TM_LOCKED;
        endcase
    end

    // state and register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TM_OFF;
            test_q  <= '0;
            ctrl_q  <= CTRL_RST;
        end else begin
            state_q <= state_d;
            test_q  <= test_d;
            ctrl_q  <= ctrl_d;
        end
    end

    // output process
    always_comb begin
        locked    = 1'b0;
        force_all = 1'b0;
        unique case (state_q)
            TM_OFF, TM_SSB_ONLY, TM_ARMED: locked = 1'b0;
            TM_LOCKED:                     locked = 1'b1;
        endcase
        if ((wr_test || wr_ctrl) && state_d == TM_LOCKED)
            force_all = 1'b1;
    end

    AST_STATE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TM_LOCKED) == (ctrl_q[SYSTEST_BIT] && test_q[FORCE_BIT])); // R7
    AST_NO_FORCE_UNWRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_test && !wr_ctrl) |-> !force_all); // R11
endmodule

// File: rtl/mspi_irq_status.sv
module mspi_irq_status
    import mspi_irq_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ev_txe,
    input  logic [NUM_CH-1:0] ev_rxf,
    input  logic              wr_status,
    input  logic [STAT_W-1:0] wr_data,
    input  logic              locked,
    input  logic              force_all,
    output logic [STAT_W-1:0] status_q
);
    logic [STAT_W-1:0] set_vec, clr_vec, status_d;

    always_comb begin
        set_vec = '0;
        for (int n = 0; n < NUM_CH; n++) begin
            set_vec[SLICE_W*n + TXE_OFS] = ev_txe[n];
            set_vec[SLICE_W*n + RXF_OFS] = ev_rxf[n];
        end
    end

    always_comb begin
        clr_vec  = (wr_status && !locked) ? wr_data : '0;
        status_d = ((status_q & ~clr_vec) | set_vec | (force_all ? IMPL_MASK : '0)) & IMPL_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((status_q & $past(set_vec)) == $past(set_vec))); // R2
    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> ((status_q & $past(status_q)) == $past(status_q))); // R7
    AST_FORCE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        force_all |=> (status_q == IMPL_MASK)); // R8
    AST_CLEAR_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_status && !locked && !force_all && set_vec == '0)
        |=> (status_q == ($past(status_q) & ~$past(wr_data)))); // R3
endmodule

// File: rtl/mspi_irq_out.sv
module mspi_irq_out
    import mspi_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_enable,
    input  logic [STAT_W-1:0] wr_data,
    input  logic [STAT_W-1:0] status_q,
    output logic [STAT_W-1:0] enable_q,
    output logic              irq
);
    logic pending;

    always_comb pending = |(status_q & enable_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= '0;
            irq      <= 1'b0;
        end else begin
            if (wr_enable) enable_q <= wr_data & IMPL_MASK;
            irq <= pending;
        end
    end
endmodule

// File: rtl/mspi_irq_agg.sv
module mspi_irq_agg
    import mspi_irq_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ev_txe,
    input  logic [NUM_CH-1:0] ev_rxf,
    input  logic              wr_status,
    input  logic              wr_enable,
    input  logic              wr_test,
    input  logic              wr_ctrl,
    input  logic [STAT_W-1:0] wr_data,
    output logic [STAT_W-1:0] status_q,
    output logic [STAT_W-1:0] enable_q,
    output logic [TEST_W-1:0] test_q,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              irq
);
    logic force_all;
    logic locked;

    mspi_irq_mode i_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_test   (wr_test),
        .wr_ctrl   (wr_ctrl),
        .wr_data   (wr_data[TEST_W-1:0]),
        .test_q    (test_q),
        .ctrl_q    (ctrl_q),
        .force_all (force_all),
        .locked    (locked)
    );

    mspi_irq_status #(.NUM_CH(NUM_CH)) i_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_txe    (ev_txe),
        .ev_rxf    (ev_rxf),
        .wr_status (wr_status),
        .wr_data   (wr_data),
        .locked    (locked),
        .force_all (force_all),
        .status_q  (status_q)
    );

    mspi_irq_out i_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_enable (wr_enable),
        .wr_data   (wr_data),
        .status_q  (status_q),
        .enable_q  (enable_q),
        .irq       (irq)
    );

    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status_q & enable_q)) |=> irq); // R5
    AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(status_q & enable_q)) |=> !irq); // R5
    AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({wr_status, wr_enable, wr_test, wr_ctrl}) <= 1); // R3
endmodule

// File: tb/test_mspi_irq_agg.sv
module test_mspi_irq_agg;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam logic [16:0] MASK = 17'h1777F;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] ev_txe = '0, ev_rxf = '0;
    logic wr_status = 1'b0, wr_enable = 1'b0, wr_test = 1'b0, wr_ctrl = 1'b0;
    logic [16:0] wr_data = '0;
    logic [16:0] status_q, enable_q;
    logic [11:0] test_q;
    logic [3:0]  ctrl_q;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [16:0] m_status = '0, m_enable = '0;
    logic [11:0] m_test = '0;
    logic [3:0]  m_ctrl = 4'h4;
    logic        m_irq = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mspi_irq_agg #(.NUM_CH(NCH)) i_mspi_irq_agg (
        .clk(clk), .rst_n(rst_n), .ev_txe(ev_txe), .ev_rxf(ev_rxf),
        .wr_status(wr_status), .wr_enable(wr_enable), .wr_test(wr_test),
        .wr_ctrl(wr_ctrl), .wr_data(wr_data), .status_q(status_q),
        .enable_q(enable_q), .test_q(test_q), .ctrl_q(ctrl_q), .irq(irq)
    );

    function automatic logic [16:0] ev_bits(logic [NCH-1:0] t, logic [NCH-1:0] r);
        logic [16:0] v = '0;
        for (int n = 0; n < NCH; n++) begin
            v[4*n]   = t[n];
            v[4*n+2] = r[n];
        end
        return v;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // one clock: drive at negedge, model at posedge, return at next negedge
    task automatic step(logic [NCH-1:0] t, logic [NCH-1:0] r,
                        logic ws, logic we, logic wt, logic wc, logic [16:0] d);
        logic [11:0] nt;
        logic [3:0]  nc;
        logic        lk, frc;
        logic [16:0] clr;
        ev_txe = t; ev_rxf = r;
        wr_status = ws; wr_enable = we; wr_test = wt; wr_ctrl = wc; wr_data = d;
        @(posedge clk);
        lk  = m_ctrl[3] && m_test[11];
        nt  = wt ? d[11:0] : m_test;
        nc  = wc ? d[3:0] : m_ctrl;
        frc = (wt || wc) && nc[3] && nt[11];
        clr = (ws && !lk) ? d : '0;
        m_irq    = |(m_status & m_enable);
        m_status = ((m_status & ~clr) | ev_bits(t, r) | (frc ? MASK : '0)) & MASK;
        if (we) m_enable = d & MASK;
        m_test = nt;
        m_ctrl = nc;
        @(negedge clk);
        ev_txe = '0; ev_rxf = '0;
        wr_status = 0; wr_enable = 0; wr_test = 0; wr_ctrl = 0; wr_data = '0;
    endtask

    task automatic idle();
        step('0, '0, 0, 0, 0, 0, '0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        chk("R1 status", status_q, 0);
        chk("R1 enable", enable_q, 0);
        chk("R1 test", test_q, 0);
        chk("R1 ctrl", ctrl_q, 4);
        chk("R1 irq", irq, 0);

        // R2 bit positions per channel
        step(4'b0100, 4'b0010, 0, 0, 0, 0, '0);
        chk("R2 txe ch2 bit8 rxf ch1 bit6", status_q, 17'h00140);
        idle();
        chk("R2 sticky", status_q, 17'h00140);

        // R4 enable mask, R5 irq delay
        step('0, '0, 0, 1, 0, 0, 17'h1FFFF);
        chk("R4 enable mask", enable_q, 17'h1777F);
        chk("R5 irq not yet", irq, 0);
        idle();
        chk("R5 irq raised", irq, 1);

        // R3 write one to clear
        step('0, '0, 1, 0, 0, 0, 17'h00100);
        chk("R3 clear bit8 only", status_q, 17'h00040);

        // R6 set beats clear
        step('0, 4'b0001, 1, 0, 0, 0, 17'h00044);
        chk("R6 set wins", status_q, 17'h00004);
        step('0, '0, 1, 0, 0, 0, 17'h00004);
        chk("R3 clear all", status_q, 0);
        idle();
        chk("R5 irq drops", irq, 0);

        // R11 no force while test mode off; R10 test width
        step('0, '0, 0, 0, 1, 0, 17'h1F800);
        chk("R10 test keeps 11:0", test_q, 12'h800);
        chk("R11 no force", status_q, 0);

        // R9 enter lock through control
        step('0, '0, 0, 0, 0, 1, 17'h0003F);
        chk("R10 ctrl keeps 3:0", ctrl_q, 4'hF);
        chk("R9 forced", status_q, 17'h1777F);

        // R7 clear ignored while locked
        step('0, '0, 1, 0, 0, 0, 17'h1FFFF);
        chk("R7 clear ignored", status_q, 17'h1777F);

        // R8 enter lock through test register
        step('0, '0, 0, 0, 1, 0, 17'h00000);
        step('0, '0, 1, 0, 0, 0, 17'h1FFFF);
        chk("R3 clear after unlock", status_q, 0);
        step('0, '0, 0, 0, 1, 0, 17'h00800);
        chk("R8 forced", status_q, 17'h1777F);

        // R11 control write clearing bit 3 leaves status
        step('0, '0, 0, 0, 0, 1, 17'h00004);
        chk("R11 no change", status_q, 17'h1777F);
        step('0, '0, 0, 0, 1, 0, 17'h00000);
        step('0, '0, 1, 0, 0, 0, 17'h1FFFF);

        // random phase against model
        for (int i = 0; i < 3000; i++) begin
            logic [NCH-1:0] t, r;
            logic [16:0] d;
            int sel;
            t = '0; r = '0;
            for (int n = 0; n < NCH; n++) begin
                t[n] = ($urandom % 6) == 0;
                r[n] = ($urandom % 6) == 0;
            end
            d   = 17'($urandom);
            sel = $urandom % 10;
            case (sel)
                0, 1, 2: step(t, r, 1, 0, 0, 0, d);
                3, 4:    step(t, r, 0, 1, 0, 0, d);
                5:       step(t, r, 0, 0, 1, 0, d);
                6:       step(t, r, 0, 0, 0, 1, d);
                default: step(t, r, 0, 0, 0, 0, d);
            endcase
            chk("R3 status", status_q, m_status);
            chk("R4 enable", enable_q, m_enable);
            chk("R10 test", test_q, m_test);
            chk("R10 ctrl", ctrl_q, m_ctrl);
            chk("R5 irq", irq, m_irq);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule